// File: doc/BRIEF.md
# Buck Converter Soft-Start and Fault Sequencer

This block is the digital supervisor of a voltage-mode synchronous buck regulator. It sits between the input-supply lockout comparator and the converter's analog loop. Once the supply is reported good, it first holds the error amplifier just under the ramp valley for a programmable number of system clocks. It then raises a digital reference code in equal steps up to full scale, one step per fixed group of switching cycles. After that it regulates and watches a feedback window.

The window has two comparator flags. A low excursion restarts the staircase. A high excursion shuts the converter down until the supply is cycled. A current-limit request from the power stage turns both switches off and waits four staircase lengths before it tries again. Switching cycles are counted only through a one-clock tick input, so the staircase and the retry wait follow the converter frequency and not the system clock.

Top module: `buck_start_ctrl`

## Requirements
- R1: While `rst` is high or `uvlo_ok` is low at a clock edge, after that edge `ref_code` is 0 and `ss_active`, `pwr_good`, `gate_en` and `prebias_en` are all low.
- R2: After the first edge with `uvlo_ok` high from the off state, `prebias_en` is high, `gate_en` is low and `ref_code` is 0 for exactly PRESTART_CLKS clock periods. On the next edge the staircase starts with `ss_active` high, `gate_en` high and `ref_code` = 1.
- R3: During the staircase `ref_code` equals step index + 1, with the step index running 0 to STEPS-1. After the final tick of the last step `ss_active` falls and `ref_code` holds STEPS.
- R4: A step advances only after CYC_PER_STEP clocks with `sw_tick` high. Clocks without a tick leave `ref_code` and the state unchanged.
- R5: `fb_over` and `fb_under` are ignored while `ss_active` is high.
- R6: `pwr_good` is high only after the staircase has finished and both window flags are low. It falls in the same cycle that either flag rises.
- R7: After the staircase, `fb_under` high at an edge starts a new staircase: `ss_active` high and `ref_code` = 1 after that edge.
- R8: After the staircase, `fb_over` high at an edge latches the block off: `gate_en` low and `ref_code` 0 from then on, whatever the flags, ticks or current-limit requests.
- R9: `ilim_req` during the staircase or after it turns `gate_en` off and sets `ref_code` to 0 at the next edge. After 4·STEPS·CYC_PER_STEP ticks a new staircase begins at code 1.
- R10: When several fault inputs are high in the same cycle after the staircase, overvoltage wins over current limit, and current limit wins over undervoltage.
- R11: `ilim_req` has no effect during the pre-start delay.
- R12: Dropping `uvlo_ok` clears the overvoltage latch. Raising it again repeats the pre-start delay of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok | input | 1 | Input supply above the lockout threshold |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| fb_over | input | 1 | Feedback above the upper window limit |
| fb_under | input | 1 | Feedback below the lower window limit |
| ilim_req | input | 1 | Current-limit fault request |
| ref_code | output | CODE_W | Reference DAC code, 0 to STEPS |
| ss_active | output | 1 | Staircase in progress |
| pwr_good | output | 1 | Output regulated inside the window |
| gate_en | output | 1 | Enable for both switch gate drivers |
| prebias_en | output | 1 | Hold the error amplifier below the ramp valley |

## Verification
The fault arbiter can receive overvoltage, current limit and undervoltage in the same cycle. The bench provokes this in the regulating state twice: once with current limit and undervoltage raised together, and once with overvoltage and current limit raised together. The first case must lead to the retry wait, and the bench checks it by counting exactly the wait length in ticks before code 1 reappears. The second case must latch off. The bench judges it by keeping ticks running past the full retry window and confirming that the outputs stay dark, which separates a latch from a wait. A small configuration lets every staircase tick be swept, with the expected code worked out arithmetically as tick/CYC_PER_STEP + 1.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PRE,
        ST_SS,
        ST_RUN,
        ST_CLW,
        ST_OVL
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_OV,
        EV_ILIM,
        EV_UV
    } fault_ev_t;

    typedef struct packed {
        logic ss_active;
        logic gate_en;
        logic prebias_en;
    } drive_t;

    // retry wait after a current-limit trip, in staircase lengths
    localparam int ILIM_WAIT_MULT = 4;

    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bsc_modcnt.sv
module bsc_modcnt #(
    parameter  int LIMIT = 2,
    localparam int W     = bsc_pkg::cnt_w(LIMIT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic wrap;
    assign wrap = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // R4: nothing moves without an increment
    a_r4_hold_without_inc: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt));

endmodule

// File: rtl/bsc_fault_arb.sv
module bsc_fault_arb
    import bsc_pkg::*;
(
    input  logic      in_ss,
    input  logic      in_run,
    input  logic      over,
    input  logic      under,
    input  logic      ilim,
    output fault_ev_t ev,
    output logic      pgood
);

    always_comb begin
        if (in_run && over) begin
            ev = EV_OV;
        end else if ((in_run || in_ss) && ilim) begin
            ev = EV_ILIM;
        end else if (in_run && under) begin
            ev = EV_UV;
        end else begin
            ev = EV_NONE;
        end
    end

    assign pgood = in_run && !over && !under;

endmodule

// File: rtl/bsc_out_map.sv
module bsc_out_map
    import bsc_pkg::*;
#(
    parameter  int STEPS  = 32,
    localparam int CODE_W = bsc_pkg::cnt_w(STEPS + 1),
    localparam int STEP_W = bsc_pkg::cnt_w(STEPS)
) (
    input  seq_state_t        st,
    input  logic [STEP_W-1:0] step_idx,
    output logic [CODE_W-1:0] ref_code,
    output drive_t            drv
);

    always_comb begin
        ref_code = '0;
        drv      = '0;
        unique case (st)
            ST_PRE: begin
                drv.prebias_en = 1'b1;
            end
            ST_SS: begin
                ref_code      = CODE_W'(step_idx) + CODE_W'(1);
                drv.ss_active = 1'b1;
                drv.gate_en   = 1'b1;
            end
            ST_RUN: begin
                ref_code    = CODE_W'(STEPS);
                drv.gate_en = 1'b1;
            end
            default: begin
                ref_code = '0;
                drv      = '0;
            end
        endcase
    end

endmodule

// File: rtl/buck_start_ctrl.sv
module buck_start_ctrl
    import bsc_pkg::*;
#(
    parameter  int PRESTART_CLKS = 50000,
    parameter  int STEPS         = 32,
    parameter  int CYC_PER_STEP  = 32,
    localparam int CODE_W        = bsc_pkg::cnt_w(STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uvlo_ok,
    input  logic              sw_tick,
    input  logic              fb_over,
    input  logic              fb_under,
    input  logic              ilim_req,
    output logic [CODE_W-1:0] ref_code,
    output logic              ss_active,
    output logic              pwr_good,
    output logic              gate_en,
    output logic              prebias_en
);

    localparam int WAIT_TICKS = ILIM_WAIT_MULT * STEPS * CYC_PER_STEP;
    localparam int PRE_W      = cnt_w(PRESTART_CLKS);
    localparam int CYC_W      = cnt_w(CYC_PER_STEP);
    localparam int STEP_W     = cnt_w(STEPS);
    localparam int WAIT_W     = cnt_w(WAIT_TICKS);

    seq_state_t st_q, st_d;
    fault_ev_t  ev;
    drive_t     drv;

    logic in_pre, in_ss, in_run, in_clw;
    logic pre_last, cyc_last, step_last, wait_last;

    logic [PRE_W-1:0]  pre_cnt;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [STEP_W-1:0] step_cnt;
    logic [WAIT_W-1:0] wait_cnt;

    assign in_pre = (st_q == ST_PRE);
    assign in_ss  = (st_q == ST_SS);
    assign in_run = (st_q == ST_RUN);
    assign in_clw = (st_q == ST_CLW);

    // pre-start delay, counted in system clocks
    bsc_modcnt #(.LIMIT(PRESTART_CLKS)) u_pre_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!in_pre),
        .inc (1'b1),
        .cnt (pre_cnt)
    );

    // switching cycles within one staircase step
    bsc_modcnt #(.LIMIT(CYC_PER_STEP)) u_cyc_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!in_ss),
        .inc (sw_tick),
        .cnt (cyc_cnt)
    );

    // staircase step index
    bsc_modcnt #(.LIMIT(STEPS)) u_step_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!in_ss),
        .inc (sw_tick && cyc_last),
        .cnt (step_cnt)
    );

    // retry wait after a current-limit trip
    bsc_modcnt #(.LIMIT(WAIT_TICKS)) u_wait_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!in_clw),
        .inc (sw_tick),
        .cnt (wait_cnt)
    );

    assign pre_last  = (pre_cnt  == PRE_W'(PRESTART_CLKS - 1));
    assign cyc_last  = (cyc_cnt  == CYC_W'(CYC_PER_STEP - 1));
    assign step_last = (step_cnt == STEP_W'(STEPS - 1));
    assign wait_last = (wait_cnt == WAIT_W'(WAIT_TICKS - 1));

    bsc_fault_arb u_arb (
        .in_ss  (in_ss),
        .in_run (in_run),
        .over   (fb_over),
        .under  (fb_under),
        .ilim   (ilim_req),
        .ev     (ev),
        .pgood  (pwr_good)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: st_d = ST_PRE;
            ST_PRE: if (pre_last) st_d = ST_SS;
            ST_SS: begin
                if (ev == EV_ILIM) begin
                    st_d = ST_CLW;
                end else if (sw_tick && cyc_last && step_last) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                unique case (ev)
                    EV_OV:   st_d = ST_OVL;
                    EV_ILIM: st_d = ST_CLW;
                    EV_UV:   st_d = ST_SS;
                    default: st_d = ST_RUN;
                endcase
            end
            ST_CLW: if (sw_tick && wait_last) st_d = ST_SS;
            ST_OVL: st_d = ST_OVL;
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !uvlo_ok) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    bsc_out_map #(.STEPS(STEPS)) u_out (
        .st       (st_q),
        .step_idx (step_cnt),
        .ref_code (ref_code),
        .drv      (drv)
    );

    assign ss_active  = drv.ss_active;
    assign gate_en    = drv.gate_en;
    assign prebias_en = drv.prebias_en;

    // R1: lockout darkens every output
    a_r1_lockout_quiet: assert property (@(posedge clk) disable iff (rst)
        !uvlo_ok |=> (ref_code == '0 && !gate_en && !ss_active && !prebias_en && !pwr_good));

    // R3: the staircase never steps down
    a_r3_staircase_up: assert property (@(posedge clk) disable iff (rst)
        (ss_active && $past(ss_active)) |-> (ref_code >= $past(ref_code)));

    // R6: power good only at full reference with the switches running
    a_r6_pg_needs_run: assert property (@(posedge clk) disable iff (rst)
        pwr_good |-> (gate_en && !ss_active && ref_code == CODE_W'(STEPS)));

    // R8: the overvoltage latch holds while the supply stays up
    a_r8_ov_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OVL && uvlo_ok) |=> (st_q == ST_OVL && !gate_en && ref_code == '0));

    // R9: an accepted current-limit trip turns the gates off
    a_r9_ilim_gates_off: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_ILIM && uvlo_ok) |=> !gate_en);

    // R10: overvoltage outranks a simultaneous current-limit request
    a_r10_ov_beats_ilim: assert property (@(posedge clk) disable iff (rst)
        (in_run && fb_over && ilim_req && uvlo_ok) |=> (st_q == ST_OVL));

endmodule

// File: tb/buck_start_ctrl_bench.sv
module buck_start_ctrl_bench;

    localparam int P    = 6;
    localparam int S    = 4;
    localparam int C    = 3;
    localparam int TOT  = S * C;
    localparam int WAIT = 4 * TOT;
    localparam int CW   = (S + 1 > 1) ? $clog2(S + 1) : 1;

    logic          clk = 1'b0;
    logic          rst, uvlo_ok, sw_tick, fb_over, fb_under, ilim_req;
    logic [CW-1:0] ref_code;
    logic          ss_active, pwr_good, gate_en, prebias_en;

    int vecs  = 0;
    int fails = 0;

    always #4 clk = ~clk;

    buck_start_ctrl #(
        .PRESTART_CLKS (P),
        .STEPS         (S),
        .CYC_PER_STEP  (C)
    ) u_buck_start_ctrl (
        .clk        (clk),
        .rst        (rst),
        .uvlo_ok    (uvlo_ok),
        .sw_tick    (sw_tick),
        .fb_over    (fb_over),
        .fb_under   (fb_under),
        .ilim_req   (ilim_req),
        .ref_code   (ref_code),
        .ss_active  (ss_active),
        .pwr_good   (pwr_good),
        .gate_en    (gate_en),
        .prebias_en (prebias_en)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic exp_all(input string tag, input int r, input int ss, input int pg,
                           input int ge, input int pb);
        check(tag, "ref_code", int'(ref_code), r);
        check(tag, "ss_active", int'(ss_active), ss);
        check(tag, "pwr_good", int'(pwr_good), pg);
        check(tag, "gate_en", int'(gate_en), ge);
        check(tag, "prebias_en", int'(prebias_en), pb);
    endtask

    task automatic step(input logic tk);
        sw_tick = tk;
        @(posedge clk);
        @(negedge clk);
        sw_tick = 1'b0;
    endtask

    // R2 and R11: delay from the off state, current limit held high throughout
    task automatic prestart();
        ilim_req = 1'b1;
        for (int k = 1; k <= P; k++) begin
            step(1'b0);
            exp_all("R2 R11 prestart", 0, 0, 0, 0, 1);
        end
        ilim_req = 1'b0;
        step(1'b0);
        exp_all("R2 staircase entry", 1, 1, 0, 1, 0);
    endtask

    // R3, R4, R5: sweep every tick of a staircase
    task automatic run_ss(input bit noisy);
        for (int t = 0; t < TOT; t++) begin
            if (noisy) begin
                fb_over  = 1'b1;
                fb_under = 1'b1;
                step(1'b0);
                exp_all("R4 R5 idle with flags", t / C + 1, 1, 0, 1, 0);
                fb_over  = 1'b0;
                fb_under = 1'b0;
            end
            step(1'b1);
            if (t == TOT - 1) begin
                exp_all("R3 final", S, 0, 1, 1, 0);
            end else begin
                exp_all("R3 step", (t + 1) / C + 1, 1, 0, 1, 0);
            end
        end
    endtask

    // R9: retry wait in ticks, with an ignored overvoltage flag
    task automatic cl_wait();
        fb_over = 1'b1;
        for (int w = 0; w < WAIT; w++) begin
            step(1'b1);
            if (w < WAIT - 1) begin
                exp_all("R9 wait", 0, 0, 0, 0, 0);
            end else begin
                exp_all("R9 resume", 1, 1, 0, 1, 0);
            end
        end
        fb_over = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; uvlo_ok = 1'b0; sw_tick = 1'b0;
        fb_over = 1'b0; fb_under = 1'b0; ilim_req = 1'b0;
        @(negedge clk);
        repeat (3) step(1'b0);
        exp_all("R1 reset", 0, 0, 0, 0, 0);

        rst = 1'b0; fb_over = 1'b1; ilim_req = 1'b1;
        repeat (3) step(1'b1);
        exp_all("R1 lockout", 0, 0, 0, 0, 0);
        fb_over = 1'b0; ilim_req = 1'b0;

        uvlo_ok = 1'b1;
        prestart();
        run_ss(1'b1);

        check("R6 regulating", "pwr_good", int'(pwr_good), 1);
        fb_over = 1'b1; #1;
        check("R6 over flag", "pwr_good", int'(pwr_good), 0);
        fb_over = 1'b0; fb_under = 1'b1; #1;
        check("R6 under flag", "pwr_good", int'(pwr_good), 0);
        step(1'b0);
        fb_under = 1'b0;
        exp_all("R7 restart", 1, 1, 0, 1, 0);

        run_ss(1'b0);
        ilim_req = 1'b1; fb_under = 1'b1;
        step(1'b0);
        ilim_req = 1'b0; fb_under = 1'b0;
        exp_all("R10 ilim over uv", 0, 0, 0, 0, 0);
        cl_wait();

        step(1'b1); step(1'b1); step(1'b1);
        exp_all("R3 second step", 2, 1, 0, 1, 0);
        ilim_req = 1'b1;
        step(1'b0);
        ilim_req = 1'b0;
        exp_all("R9 trip in staircase", 0, 0, 0, 0, 0);
        cl_wait();

        run_ss(1'b0);
        fb_over = 1'b1; ilim_req = 1'b1;
        step(1'b0);
        exp_all("R10 ov over ilim", 0, 0, 0, 0, 0);
        fb_under = 1'b1;
        repeat (WAIT + 12) step(1'b1);
        exp_all("R8 latched past wait", 0, 0, 0, 0, 0);
        fb_over = 1'b0; fb_under = 1'b0; ilim_req = 1'b0;
        repeat (3) step(1'b1);
        exp_all("R8 latched flags clear", 0, 0, 0, 0, 0);

        uvlo_ok = 1'b0;
        step(1'b0);
        exp_all("R12 lockout clears", 0, 0, 0, 0, 0);
        uvlo_ok = 1'b1;
        prestart();
        run_ss(1'b0);
        fb_over = 1'b1;
        step(1'b0);
        fb_over = 1'b0;
        exp_all("R8 lone overvoltage", 0, 0, 0, 0, 0);
        repeat (WAIT + 4) step(1'b1);
        exp_all("R8 still latched", 0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule